// File: doc/BRIEF.md
# Periodic Rate, Square-Wave and Interrupt Controller

This block turns a 32.768 kHz clock enable into a 15-stage binary countdown chain and picks one of its stages with a 4-bit rate code. That single picked stage does two jobs. It drives the square-wave pin, and each rising edge of it raises the periodic flag. The oscillator and chain are run, held in reset or stopped by a 3-bit control pattern.

The block also takes one-cycle alarm and update-ended event pulses from the timekeeper. It keeps three sticky flags in a status byte that clears when it is read. Events that land during a read are held and then applied. The interrupt request is an open-drain pull-down: it pulls low while any flag meets its enable. An active-low reset input clears the enables and flags but leaves the countdown chain alone.

All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready handshake.

Top module: `intr_rate_sqw_ctrl`

## Requirements
- R1: `div_ctl` 3'b010 advances the chain by one on every `tick_32k`. Patterns 3'b110 and 3'b111 hold the chain at zero, so `sqw` reads 0 one cycle later. Every other pattern freezes the chain.
- R2: `rate_sel` picks the stage. Code 0 gives no output and no periodic flag. Code 1 gives a period of 128 ticks and code 2 a period of 256 ticks. Codes 3 to 15 give a period of 2^(n-1) ticks, so code 3 is 4 ticks and code 15 is 16384 ticks.
- R3: `sqw` follows the picked stage while SQWE (control bit 3) is 1, and is 0 while SQWE is 0.
- R4: Each rising edge of the picked stage sets PF (status bit 6) on the next clock, whatever PIE holds.
- R5: An `alarm_evt` pulse sets AF (status bit 5) and an `upd_evt` pulse sets UF (status bit 4) one cycle later, whatever the enables hold.
- R6: IRQF (status bit 7) and `irq_od_low` are 1 exactly while some flag and its enable are both 1. The enables are PIE = control bit 6, AIE = bit 5 and UIE = bit 4. Writing an enable over a pending flag raises the request on the next cycle.
- R7: The status byte stays unchanged while `stat_rd` is high. The cycle after `stat_rd` falls, every flag and IRQF are clear unless an event arrived.
- R8: Events that arrive while `stat_rd` is high do not appear during the read. They appear in the status byte right after the read ends.
- R9: While `rst_n` is low, the enables, flags and request are 0 and control writes are ignored. The countdown chain keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of enables and flags |
| tick_32k | input | 1 | 32.768 kHz clock enable for the chain |
| div_ctl | input | 3 | Oscillator/chain control pattern |
| rate_sel | input | 4 | Stage select code |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: PIE b6, AIE b5, UIE b4, SQWE b3 |
| alarm_evt | input | 1 | Alarm event pulse |
| upd_evt | input | 1 | Update-ended event pulse |
| stat_rd | input | 1 | Status read cycle, high for its duration |
| stat_rdata | output | 8 | Status byte: IRQF b7, PF b6, AF b5, UF b4 |
| irq_od_low | output | 1 | Open-drain pull-down enable for the request pad |
| sqw | output | 1 | Square-wave output |

## Verification
A miscounted chain or a wrong tap index shows up on `sqw` within one period of the picked stage. It also skews the PF timing in the status byte by the same amount. A lost or early-cleared flag shows up in `stat_rdata` and on `irq_od_low` on the very next cycle. The reference model is compared on every clock, so a slip of a single cycle in flag set, read-clear or hold-over timing is caught where it happens.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DIV_STAGES = 15;
  localparam int RATE_W     = 4;
  localparam int NUM_SRC    = 3;

  // source vector order: [2] periodic, [1] alarm, [0] update-ended
  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } src_vec_t;

  // chain bit that carries the stage for a rate code (code 0 is unused)
  function automatic int tap_index(input int code);
    if (code < 3) return code + 5;
    return code - 2;
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              tick,
  input  logic [2:0]        ctl,
  output logic [STAGES-1:0] chain
);
  logic hold_rst, running;

  assign hold_rst = (ctl[2:1] == 2'b11);
  assign running  = (ctl == 3'b010);

  // not cleared by the block reset: the chain belongs to timekeeping
  always_ff @(posedge clk) begin
    if (hold_rst)
      chain <= '0;
    else if (running && tick)
      chain <= chain + 1'b1;
  end
endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
  import rtc_irq_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RW     = 4
) (
  input  logic              clk,
  input  logic [STAGES-1:0] chain,
  input  logic [RW-1:0]     rate,
  output logic              tap,
  output logic              tap_rise
);
  localparam int NCODES = 1 << RW;

  logic [NCODES-1:0] cand;
  logic              tap_q;

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    if (c == 0 || tap_index(c) >= STAGES) begin : g_off
      assign cand[c] = 1'b0;
    end else begin : g_on
      assign cand[c] = chain[tap_index(c)];
    end
  end

  assign tap = cand[rate];

  always_ff @(posedge clk) tap_q <= tap;

  assign tap_rise = tap & ~tap_q;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  src_vec_t en,
  input  logic     rd,
  output src_vec_t flags,
  output logic     irqf
);
  src_vec_t held;
  logic     rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      held  <= '0;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= rd;
      if (rd) begin
        held <= held | evt;        // keep read data stable
      end else if (rd_q) begin
        flags <= held | evt;       // read done: clear, then apply hold-over
        held  <= '0;
      end else begin
        flags <= flags | evt;
      end
    end
  end

  assign irqf = |(flags & en);
endmodule

// File: rtl/intr_rate_sqw_ctrl.sv
module intr_rate_sqw_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int STAGES = DIV_STAGES,
  parameter int RW     = RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_32k,
  input  logic [2:0]    div_ctl,
  input  logic [RW-1:0] rate_sel,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  input  logic          alarm_evt,
  input  logic          upd_evt,
  input  logic          stat_rd,
  output logic [7:0]    stat_rdata,
  output logic          irq_od_low,
  output logic          sqw
);
  logic [STAGES-1:0] chain;
  logic              tap, tap_rise, sqwe, irqf;
  src_vec_t          en, evt, flags;

  rtc_divider #(.STAGES(STAGES)) u_div (
    .clk(clk), .tick(tick_32k), .ctl(div_ctl), .chain(chain)
  );

  rtc_tap_sel #(.STAGES(STAGES), .RW(RW)) u_tap (
    .clk(clk), .chain(chain), .rate(rate_sel), .tap(tap), .tap_rise(tap_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      sqwe <= 1'b0;
    end else if (ctrl_we) begin
      en   <= '{per: ctrl_wdata[6], alm: ctrl_wdata[5], upd: ctrl_wdata[4]};
      sqwe <= ctrl_wdata[3];
    end
  end

  assign evt = '{per: tap_rise, alm: alarm_evt, upd: upd_evt};

  rtc_irq_flags u_flg (
    .clk(clk), .rst_n(rst_n), .evt(evt), .en(en), .rd(stat_rd),
    .flags(flags), .irqf(irqf)
  );

  assign stat_rdata = {irqf, flags.per, flags.alm, flags.upd, 4'b0000};
  assign irq_od_low = irqf;
  assign sqw        = sqwe & tap;
endmodule

// File: rtl/intr_rate_sqw_chk.sv
module intr_rate_sqw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] div_ctl,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic       alarm_evt,
  input logic       upd_evt,
  input logic       stat_rd,
  input logic [7:0] stat_rdata,
  input logic       irq_od_low,
  input logic       sqw
);
  p_chain_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |=> !sqw);

  p_alarm_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_evt && !stat_rd) |=> stat_rdata[5]);

  p_update_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !stat_rd) |=> stat_rdata[4]);

  p_enable_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[5] && stat_rdata[5] && !stat_rd && !$past(stat_rd))
      |=> irq_od_low);

  p_read_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && $past(stat_rd)) |-> $stable(stat_rdata[6:4]));

  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      p_reset_quiet_r9: assert (!irq_od_low && stat_rdata == 8'h00);
    end
  end
endmodule

bind intr_rate_sqw_ctrl intr_rate_sqw_chk u_chk (.*);

// File: tb/intr_rate_sqw_ctrl_test.sv
module intr_rate_sqw_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b1;
  logic [2:0] div_ctl = 3'b110;
  logic [3:0] rate_sel = 4'd0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       alarm_evt = 1'b0;
  logic       upd_evt = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_rdata;
  logic       irq_od_low;
  logic       sqw;

  int    checks = 0, errors = 0, cycles = 0;
  string phase = "R9";
  bit    cmp_on = 0;
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_rate_sqw_ctrl uut (.*);

  // behavioural reference model
  int       m_cnt = 0;
  bit       m_prev = 0;
  bit [3:0] men = 0;   // pie aie uie sqwe
  bit [2:0] mf = 0;    // pf af uf
  bit [2:0] mh = 0;
  bit       mrd = 0;

  function automatic bit mtap(input int cnt, input int code);
    int half;
    if (code == 0) return 0;
    half = (code == 1) ? 64 : (code == 2) ? 128 : (1 << (code - 2));
    return ((cnt / half) % 2) == 1;
  endfunction

  always @(posedge clk) begin
    bit tp;
    bit [2:0] ev;
    tp = mtap(m_cnt, int'(rate_sel));
    ev = {tp && !m_prev, alarm_evt, upd_evt};
    m_prev = tp;
    if (div_ctl[2:1] == 2'b11) m_cnt = 0;
    else if (div_ctl == 3'b010 && tick_32k) m_cnt = (m_cnt + 1) % 32768;
    if (!rst_n) begin
      men = 0; mf = 0; mh = 0; mrd = 0;
    end else begin
      if (ctrl_we) men = ctrl_wdata[6:3];
      if (stat_rd) mh = mh | ev;
      else if (mrd) begin mf = mh | ev; mh = 0; end
      else mf = mf | ev;
      mrd = stat_rd;
    end
    cycles++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit       e_sqw, e_irq;
    bit [7:0] e_rd;
    if (cmp_on && !done) begin
      if (!rst_n) begin men = 0; mf = 0; mh = 0; mrd = 0; end
      e_sqw = men[0] && mtap(m_cnt, int'(rate_sel));
      e_irq = |(mf & men[3:1]);
      e_rd  = {e_irq, mf, 4'b0000};
      chk(sqw === e_sqw, {phase, " sqw"}, int'(sqw), int'(e_sqw));
      chk(irq_od_low === e_irq, {phase, " irq"}, int'(irq_od_low), int'(e_irq));
      chk(stat_rdata === e_rd, {phase, " status"}, int'(stat_rdata), int'(e_rd));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    step();
    ctrl_we = 1'b0;
  endtask

  task automatic measure(input int code, input int exp, input string tag);
    int n;
    rate_sel = code[3:0];
    step(3);
    while (sqw !== 1'b0) step();
    while (sqw !== 1'b1) step();
    n = 0;
    step(); n++;
    while (sqw !== 1'b0) begin step(); n++; end
    while (sqw !== 1'b1) begin step(); n++; end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < WATCHDOG) @(posedge clk);
    chk(0, "watchdog", cycles, WATCHDOG);
    finish_run();
  end

  initial begin
    bit s0;
    step(4);
    cmp_on = 1;
    step();
    // R9: reset state
    chk(stat_rdata == 8'h00 && !irq_od_low && !sqw, "R9 reset state",
        int'(stat_rdata), 0);
    rst_n = 1'b1; div_ctl = 3'b010;
    phase = "R3";
    wr_ctrl(8'h08);
    // R2: stage periods
    phase = "R2";
    measure(3, 4, "R2 code3 period");
    measure(6, 32, "R2 code6 period");
    measure(1, 128, "R2 code1 period");
    measure(2, 256, "R2 code2 period");
    measure(15, 16384, "R2 code15 period");
    rate_sel = 4'd0;
    step(300);
    chk(!sqw, "R2 code0 silent", int'(sqw), 0);
    // R4: periodic flag without enable
    phase = "R4";
    rate_sel = 4'd3;
    step(10);
    chk(stat_rdata[6] && !irq_od_low, "R4 pf set, pie off", int'(stat_rdata), 8'h40);
    rate_sel = 4'd0;
    step(2);
    // R7: read clears
    phase = "R7";
    stat_rd = 1'b1; step(); stat_rd = 1'b0; step();
    chk(stat_rdata == 8'h00, "R7 read clears", int'(stat_rdata), 0);
    // R3: sqwe off
    phase = "R3";
    wr_ctrl(8'h00);
    rate_sel = 4'd3;
    step(20);
    chk(!sqw, "R3 sqw gated", int'(sqw), 0);
    rate_sel = 4'd0;
    step(); stat_rd = 1'b1; step(); stat_rd = 1'b0; step();
    // R5 / R6
    phase = "R5";
    alarm_evt = 1'b1; step(); alarm_evt = 1'b0;
    chk(stat_rdata == 8'h20 && !irq_od_low, "R5 alarm flag", int'(stat_rdata), 8'h20);
    phase = "R6";
    wr_ctrl(8'h20);
    chk(irq_od_low && stat_rdata == 8'hA0, "R6 pending raises irq", int'(stat_rdata), 8'hA0);
    // R8: hold-over during read
    phase = "R8";
    stat_rd = 1'b1; step();
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    step();
    chk(stat_rdata == 8'hA0, "R8 stable during read", int'(stat_rdata), 8'hA0);
    stat_rd = 1'b0; step();
    chk(stat_rdata == 8'h10 && !irq_od_low, "R8 held event applied", int'(stat_rdata), 8'h10);
    phase = "R6";
    wr_ctrl(8'h10);
    chk(irq_od_low, "R6 update irq", int'(irq_od_low), 1);
    // R9: reset clears, writes ignored
    phase = "R9";
    wr_ctrl(8'h78);
    rst_n = 1'b0;
    wr_ctrl(8'h78);
    chk(!irq_od_low && stat_rdata == 8'h00, "R9 reset clears", int'(stat_rdata), 0);
    rst_n = 1'b1;
    alarm_evt = 1'b1; step(); alarm_evt = 1'b0;
    chk(!irq_od_low && stat_rdata == 8'h20, "R9 enables cleared", int'(irq_od_low), 0);
    // R1: chain control
    phase = "R1";
    wr_ctrl(8'h08);
    rate_sel = 4'd6;
    step(5);
    div_ctl = 3'b000;
    s0 = sqw;
    step(100);
    chk(sqw == s0, "R1 stopped chain frozen", int'(sqw), int'(s0));
    div_ctl = 3'b110;
    step(2);
    chk(!sqw, "R1 chain held in reset", int'(sqw), 0);
    div_ctl = 3'b010;
    step(40);
    step();
    finish_run();
  end
endmodule